// File: doc/BRIEF.md
# Delayed Branch Resolution Unit

This block resolves a conditional branch that waits on a condition code and decides what happens to the one instruction slot that follows it. Each cycle it can take a decoded 32-bit branch word, the program counter of that branch, the four integer flags and a two-bit floating-point compare state. One clock later it reports whether the branch is taken, the computed target, a fetch redirect request and a squash request for the delay-slot instruction.

The branch word carries an annul bit. When the annul bit is clear the delay slot always runs. When it is set, a conditional branch keeps its delay slot only if the branch is taken. The unconditional forms (always and never) drop their delay slot whenever the annul bit is set. A word that is not a recognised branch leaves every output low.

Top module: `br_resolve`

## Requirements
- R1: While rst_ni is low, and on the first sample after it rises with no branch presented, taken_o, squash_o, redirect_o are 0 and target_o is all zeros.
- R2: Outputs reflect the word sampled at the previous rising edge with valid_i high; a cycle after one with valid_i low shows all outputs at 0.
- R3: Word layout: bits 31:30 must be 0, bit 29 is the annul bit, bits 28:25 the condition selector, bits 24:22 the class field, bits 21:0 the displacement. Class 2 tests the integer flags, class 6 the floating-point state; any other class, or a nonzero value in bits 31:30, drives all outputs to 0.
- R4: Integer flags are icc_i[3]=N, icc_i[2]=Z, icc_i[1]=V, icc_i[0]=C. Selectors 1..7 test Z, Z|(N^V), N^V, C|Z, C, N, V respectively.
- R5: Selector 0 is never taken, selector 8 is always taken, and selector 8+k (k=1..7) is the logical inverse of selector k, for both classes.
- R6: fcc_i encodes 0=equal, 1=less, 2=greater, 3=unordered. Floating selectors 1..7 are taken for {L,G,U}, {L,G}, {L,U}, {L}, {G,U}, {G}, {U} respectively.
- R7: For a recognised branch, target_o = pc_i + (sign-extended displacement << 2), modulo 2^AW.
- R8: With the annul bit clear, squash_o stays 0 whatever the outcome.
- R9: With the annul bit set on selectors other than 0 and 8, squash_o is the inverse of taken_o.
- R10: With the annul bit set on selector 0 or 8, squash_o is 1.
- R11: redirect_o equals taken_o in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A branch word is presented this cycle |
| insn_i | input | 32 | Decoded branch word |
| pc_i | input | AW | Address of the branch |
| icc_i | input | 4 | Integer flags N,Z,V,C |
| fcc_i | input | 2 | Floating-point compare state |
| taken_o | output | 1 | Branch taken |
| target_o | output | AW | Branch target address |
| squash_o | output | 1 | Discard the delay-slot instruction |
| redirect_o | output | 1 | Request fetch to go to target_o |

## Verification
The redirect and the squash can both fire in the same cycle, which happens for an annulled branch-always: fetch must jump and the already-fetched slot must be dropped together. The sweep provokes this by presenting selector 8 with the annul bit set under every flag pattern and judges that taken, redirect and squash are all high in the one sampled cycle, while an annulled taken conditional must show redirect without squash. Back-to-back words and an idle cycle right after a branch check that one result never leaks into the next cycle.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int unsigned DISP_W = 22;

  localparam logic [2:0] CLS_INT = 3'd2;
  localparam logic [2:0] CLS_FP  = 3'd6;

  typedef enum logic [1:0] {
    FCC_EQ = 2'd0,
    FCC_LT = 2'd1,
    FCC_GT = 2'd2,
    FCC_UN = 2'd3
  } fcc_e;

  typedef struct packed {
    logic [1:0]        op;
    logic              annul;
    logic [3:0]        sel;
    logic [2:0]        cls;
    logic [DISP_W-1:0] disp;
  } br_word_t;
endpackage

// File: rtl/br_icc_eval.sv
module br_icc_eval (
  input  logic [3:0] sel_i,
  input  logic [3:0] icc_i,
  output logic       hit_o
);
  logic n, z, v, c, base;
  assign {n, z, v, c} = icc_i;

  always_comb begin
    unique case (sel_i[2:0])
      3'd0: base = 1'b0;
      3'd1: base = z;
      3'd2: base = z | (n ^ v);
      3'd3: base = n ^ v;
      3'd4: base = c | z;
      3'd5: base = c;
      3'd6: base = n;
      default: base = v;
    endcase
  end

  // upper half of the selector space inverts the lower half
  assign hit_o = base ^ sel_i[3];
endmodule

// File: rtl/br_fcc_eval.sv
module br_fcc_eval
  import br_pkg::*;
(
  input  logic [3:0] sel_i,
  input  logic [1:0] fcc_i,
  output logic       hit_o
);
  logic [3:0] state_oh, mask;

  // one-hot on {U,G,L,E}
  assign state_oh = 4'b0001 << fcc_i;

  always_comb begin
    unique case (sel_i[2:0])
      3'd0: mask = 4'b0000;
      3'd1: mask = 4'b1110;
      3'd2: mask = 4'b0110;
      3'd3: mask = 4'b1010;
      3'd4: mask = 4'b0010;
      3'd5: mask = 4'b1100;
      3'd6: mask = 4'b0100;
      default: mask = 4'b1000;
    endcase
  end

  assign hit_o = (|(mask & state_oh)) ^ sel_i[3];
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen
  import br_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0]     pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [AW-1:0]     target_o
);
  localparam int unsigned EXT_W = AW - DISP_W - 2;

  logic [AW-1:0] offset;
  assign offset   = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, 2'b00};
  assign target_o = pc_i + offset;
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter bit          FP_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [31:0]   insn_i,
  input  logic [AW-1:0] pc_i,
  input  logic [3:0]    icc_i,
  input  logic [1:0]    fcc_i,
  output logic          taken_o,
  output logic [AW-1:0] target_o,
  output logic          squash_o,
  output logic          redirect_o
);
  br_word_t      w;
  logic          is_br, use_int, use_fp, known;
  logic          int_hit, fp_hit, hit, uncond;
  logic          taken_d, squash_d;
  logic [AW-1:0] tgt;
  logic          taken_q, squash_q;
  logic [AW-1:0] target_q;

  assign w = br_word_t'(insn_i);

  br_icc_eval u_icc (
    .sel_i (w.sel),
    .icc_i (icc_i),
    .hit_o (int_hit)
  );

  generate
    if (FP_EN) begin : g_fp
      br_fcc_eval u_fcc (
        .sel_i (w.sel),
        .fcc_i (fcc_i),
        .hit_o (fp_hit)
      );
    end else begin : g_no_fp
      assign fp_hit = 1'b0;
    end
  endgenerate

  br_target_gen #(.AW(AW)) u_tgt (
    .pc_i     (pc_i),
    .disp_i   (w.disp),
    .target_o (tgt)
  );

  always_comb begin
    is_br    = valid_i && (w.op == 2'b00);
    use_int  = is_br && (w.cls == CLS_INT);
    use_fp   = FP_EN && is_br && (w.cls == CLS_FP);
    known    = use_int || use_fp;
    hit      = use_int ? int_hit : fp_hit;
    uncond   = (w.sel[2:0] == 3'd0);
    taken_d  = known && hit;
    // annulled: unconditional forms always drop the slot, others only when not taken
    squash_d = known && w.annul && (uncond || !hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q  <= 1'b0;
      squash_q <= 1'b0;
      target_q <= '0;
    end else begin
      taken_q  <= taken_d;
      squash_q <= squash_d;
      target_q <= known ? tgt : '0;
    end
  end

  assign taken_o    = taken_q;
  assign squash_o   = squash_q;
  assign target_o   = target_q;
  assign redirect_o = taken_q;
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [31:0]   insn_i,
  input logic [AW-1:0] pc_i,
  input logic          taken_o,
  input logic [AW-1:0] target_o,
  input logic          squash_o,
  input logic          redirect_o
);
  logic good_in, annul_in, uncond_in, always_in;
  logic [AW-1:0] off_in;

  assign good_in   = valid_i && insn_i[31:30] == 2'b00 &&
                     (insn_i[24:22] == 3'd2 || insn_i[24:22] == 3'd6);
  assign annul_in  = insn_i[29];
  assign uncond_in = insn_i[27:25] == 3'd0;
  assign always_in = insn_i[28:25] == 4'd8;
  assign off_in    = {{(AW-24){insn_i[21]}}, insn_i[21:0], 2'b00};

  p_idle_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!good_in) |-> (!taken_o && !squash_o && !redirect_o && target_o == '0));

  p_always_taken_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(good_in && always_in) |-> taken_o);

  p_target_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(good_in) |-> target_o == $past(pc_i) + $past(off_in));

  p_no_annul_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(good_in && !annul_in) |-> !squash_o);

  p_annul_cond_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(good_in && annul_in && !uncond_in) |-> (squash_o != taken_o));

  p_annul_uncond_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(good_in && annul_in && uncond_in) |-> squash_o);

  p_redirect_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o == taken_o);

  always_comb begin
    if (!rst_ni) begin
      a_reset_r1: assert (!taken_o && !squash_o && !redirect_o);
    end
  end
endmodule

bind br_resolve br_resolve_chk #(.AW(AW)) u_chk (.*);

// File: tb/br_resolve_bench.sv
module br_resolve_bench;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [31:0]   insn_i = '0;
  logic [AW-1:0] pc_i = '0;
  logic [3:0]    icc_i = '0;
  logic [1:0]    fcc_i = '0;
  logic          taken_o, squash_o, redirect_o;
  logic [AW-1:0] target_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  br_resolve #(.AW(AW)) u_br_resolve (.*);

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic a, input logic [3:0] sel,
                                     input logic [2:0] cls, input logic [21:0] disp);
    return {op, a, sel, cls, disp};
  endfunction

  function automatic bit ref_int(input int sel, input logic [3:0] f);
    bit n = f[3], z = f[2], v = f[1], c = f[0];
    case (sel)
      0: return 0;            8: return 1;
      1: return z;            9: return !z;
      2: return z || (n != v); 10: return !(z || (n != v));
      3: return n != v;       11: return n == v;
      4: return c || z;       12: return !(c || z);
      5: return c;            13: return !c;
      6: return n;            14: return !n;
      7: return v;            default: return !v;
    endcase
  endfunction

  function automatic bit ref_fp(input int sel, input logic [1:0] s);
    bit e = (s == 0), l = (s == 1), g = (s == 2), u = (s == 3);
    case (sel)
      0: return 0;        8: return 1;
      1: return !e;       9: return e;
      2: return l || g;   10: return e || u;
      3: return l || u;   11: return g || e;
      4: return l;        12: return !l;
      5: return g || u;   13: return l || e;
      6: return g;        14: return !g;
      7: return u;        default: return !u;
    endcase
  endfunction

  // present one word, sample its registered result one cycle later
  task automatic apply(input logic [31:0] w, input logic [AW-1:0] pc,
                       input logic [3:0] f, input logic [1:0] fs);
    @(negedge clk_i);
    valid_i = 1'b1; insn_i = w; pc_i = pc; icc_i = f; fcc_i = fs;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 taken in reset", AW'(taken_o), '0);
    chk("R1 squash in reset", AW'(squash_o), '0);
    chk("R1 target in reset", target_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 redirect after reset", AW'(redirect_o), '0);
  endtask

  task automatic t_int_sweep();
    for (int s = 0; s < 16; s++)
      for (int f = 0; f < 16; f++)
        for (int a = 0; a < 2; a++) begin
          bit tk = ref_int(s, 4'(f));
          bit sq = a && ((s % 8 == 0) || !tk);
          apply(mk(2'b00, a[0], 4'(s), 3'd2, 22'h10), 32'h1000, 4'(f), 2'd0);
          chk("R4/R5 int taken", AW'(taken_o), AW'(tk));
          chk(a ? ((s % 8 == 0) ? "R10 squash" : "R9 squash") : "R8 squash",
              AW'(squash_o), AW'(sq));
          chk("R11 redirect", AW'(redirect_o), AW'(tk));
        end
  endtask

  task automatic t_fp_sweep();
    for (int s = 0; s < 16; s++)
      for (int st = 0; st < 4; st++)
        for (int a = 0; a < 2; a++) begin
          bit tk = ref_fp(s, 2'(st));
          bit sq = a && ((s % 8 == 0) || !tk);
          // integer flags set opposite to prove they are not consulted
          apply(mk(2'b00, a[0], 4'(s), 3'd6, 22'h4), 32'h2000, 4'hF, 2'(st));
          chk("R6 fp taken", AW'(taken_o), AW'(tk));
          chk("R9/R10 fp squash", AW'(squash_o), AW'(sq));
        end
  endtask

  task automatic t_bad_class();
    for (int c = 0; c < 8; c++) begin
      if (c == 2 || c == 6) continue;
      apply(mk(2'b00, 1'b1, 4'd8, 3'(c), 22'h7), 32'h3000, 4'h0, 2'd0);
      chk("R3 bad class taken", AW'(taken_o), '0);
      chk("R3 bad class squash", AW'(squash_o), '0);
      chk("R3 bad class target", target_o, '0);
    end
    for (int op = 1; op < 4; op++) begin
      apply(mk(2'(op), 1'b1, 4'd8, 3'd2, 22'h7), 32'h3000, 4'h0, 2'd0);
      chk("R3 bad op redirect", AW'(redirect_o), '0);
      chk("R3 bad op squash", AW'(squash_o), '0);
    end
  endtask

  task automatic t_target();
    logic [AW-1:0] pcs [4] = '{32'h0000_1000, 32'h0000_0004, 32'hFFFF_FFF0, 32'h8000_0000};
    logic [21:0]   ds  [4] = '{22'h00_0001, 22'h3F_FFFF, 22'h00_0010, 22'h20_0000};
    for (int i = 0; i < 4; i++) begin
      logic [AW-1:0] exp = pcs[i] + AW'($signed(ds[i])) * 4;
      apply(mk(2'b00, 1'b0, 4'd8, 3'd2, ds[i]), pcs[i], 4'h0, 2'd0);
      chk("R7 target", target_o, exp);
    end
  endtask

  task automatic t_back_to_back();
    // taken conditional, then not taken, then idle
    @(negedge clk_i);
    valid_i = 1'b1; insn_i = mk(2'b00, 1'b1, 4'd1, 3'd2, 22'h8); icc_i = 4'b0100; pc_i = 32'h40;
    @(negedge clk_i);
    chk("R2 first result taken", AW'(taken_o), 1);
    chk("R9 taken keeps slot", AW'(squash_o), 0);
    insn_i = mk(2'b00, 1'b1, 4'd1, 3'd2, 22'h8); icc_i = 4'b0000;
    @(negedge clk_i);
    chk("R2 second result taken", AW'(taken_o), 0);
    chk("R9 not taken drops slot", AW'(squash_o), 1);
    valid_i = 1'b0;
    @(negedge clk_i);
    chk("R2 idle taken", AW'(taken_o), 0);
    chk("R2 idle squash", AW'(squash_o), 0);
    chk("R2 idle target", target_o, '0);
  endtask

  initial begin
    t_reset();
    t_int_sweep();
    t_fp_sweep();
    t_bad_class();
    t_target();
    t_back_to_back();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule